// File: doc/BRIEF.md
# Stack Push/Pop Multiple Sequencer

This block carries out a multi-register stack transfer that a 16-bit instruction word describes. A push stores a chosen set of the eight low registers, and optionally the link register, below the current stack pointer. A pop loads a chosen set of the eight low registers, and optionally the program counter, from the stack pointer upward. In both cases the block then writes the new stack pointer back. Each cycle it issues at most one 32-bit word access on a request/ready memory port.

The core pipeline pulses `start_i` with the instruction while the sequencer is idle. For a push, the block reads register values through a combinational read port (`rd_sel_o`/`rd_data_i`). Loaded values and the final stack pointer leave through a single register-file write port. A one-cycle `done_o` marks the end of the transfer. Register indices on both ports use 0–7 for the low registers, 13 for the stack pointer, 14 for the link register and 15 for the program counter.

Top module: `stk_pushpop_seq`

## Requirements
- R1: While reset is held and right after it is released, `mem_req_o`, `rf_we_o` and `done_o` are all low.
- R2: The instruction is decoded as follows. Bit 11 high selects pop and low selects push. Bit 8 adds the extra register (link register on push, program counter on pop). Bit i of bits 7:0 selects low register i. All other bits have no effect.
- R3: A push stores the link register first, if it is selected, at SP−4. It then stores the selected low registers from the highest index down, and each store uses an address 4 below the one before it.
- R4: After a non-empty push, the cycle with `done_o` writes index 13 with the lowest address stored to.
- R5: A pop loads the selected low registers from the lowest index up, starting at SP, with each load 4 above the one before. Each loaded word is written to its register in the cycle its access completes.
- R6: A pop with bit 8 set loads the program counter last, from the word after the low registers, with bit 0 of the written value forced to 0.
- R7: After a non-empty pop, the cycle with `done_o` writes index 13 with SP plus 4 times the number of words loaded.
- R8: At most one access is requested per cycle. While `mem_ready_i` is low, the request, address, direction and store data stay unchanged, and no register is written.
- R9: `done_o` is high for exactly one cycle per accepted instruction, and the sequencer accepts a new `start_i` in the next cycle.
- R10: An instruction with an empty list and bit 8 clear makes no memory access and no register write, and raises `done_o` in the cycle after it is accepted.
- R11: A `start_i` pulse that arrives while a transfer is in progress is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept `insn_i` when idle |
| insn_i | input | 16 | Push/pop instruction word |
| sp_i | input | 32 | Current stack pointer |
| rd_sel_o | output | 4 | Register index to read for a store |
| rd_data_i | input | 32 | Value of register `rd_sel_o` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 4 | Register index written |
| rf_wdata_o | output | 32 | Register write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 32-bit words, an 8-entry list and 4-byte steps. At these values it can drive the all-ones list (nine words, including the extra register), single-entry lists, extra-register-only transfers and the empty list with the real address arithmetic. A behavioural model predicts each access and each register write in order. The bench runs some transfers with a pseudo-random ready pattern, so that every stall position and a stall on the final access are covered. It also runs a push and pop round trip with an odd link-register value, which exercises the bit-0 clearing on the program counter.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int          RIDX_W = 4;
    localparam logic [3:0]  REG_SP = 4'd13;
    localparam logic [3:0]  REG_LR = 4'd14;
    localparam logic [3:0]  REG_PC = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WB   = 2'd2
    } stk_state_e;

endpackage

// File: rtl/stk_pick.sv
// Picks the next register from a remaining-list mask, either lowest or
// highest index first, and returns a one-hot mask to clear it.
module stk_pick #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  mask_i,
    input  logic          hi_first_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o,
    output logic [W-1:0]  onehot_o
);

    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;

    always_comb begin
        lo_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) lo_idx = IW'(i);
        end
        hi_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (mask_i[i]) hi_idx = IW'(i);
        end
    end

    assign any_o = |mask_i;
    assign idx_o = hi_first_i ? hi_idx : lo_idx;

    for (genvar g = 0; g < W; g++) begin : g_onehot
        assign onehot_o[g] = any_o && (idx_o == IW'(g));
    end

endmodule

// File: rtl/stk_addr_unit.sv
// Address arithmetic: first address, per-access step and final stack pointer.
module stk_addr_unit #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] cur_i,
    input  logic            start_pop_i,
    input  logic            step_pop_i,
    output logic [XLEN-1:0] start_o,
    output logic [XLEN-1:0] next_o,
    output logic [XLEN-1:0] final_sp_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    assign start_o    = start_pop_i ? sp_i : (sp_i - STEP);
    assign next_o     = step_pop_i ? (cur_i + STEP) : (cur_i - STEP);
    assign final_sp_o = step_pop_i ? cur_i : (cur_i + STEP);

endmodule

// File: rtl/stk_pushpop_seq.sv
module stk_pushpop_seq
    import stk_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LIST_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int INSN_W     = 16,
    parameter int POP_BIT    = 11,
    parameter int EXTRA_BIT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [XLEN-1:0]   sp_i,
    output logic [RIDX_W-1:0] rd_sel_o,
    input  logic [XLEN-1:0]   rd_data_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [XLEN-1:0]   mem_addr_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    input  logic [XLEN-1:0]   mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              rf_we_o,
    output logic [RIDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              done_o
);

    localparam int IW = (LIST_W > 1) ? $clog2(LIST_W) : 1;
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    typedef struct packed {
        stk_state_e        state;
        logic              pop;
        logic              extra;
        logic              empty;
        logic [LIST_W-1:0] list;
        logic [XLEN-1:0]   addr;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_IDLE, pop: 1'b0, extra: 1'b0,
                                 empty: 1'b0, list: '0, addr: '0};

    seq_t seq_d, seq_q;

    logic [IW-1:0]     pick_idx;
    logic              pick_any;
    logic [LIST_W-1:0] pick_onehot;
    logic [XLEN-1:0]   addr_start;
    logic [XLEN-1:0]   addr_next;
    logic [XLEN-1:0]   sp_final;
    logic              cur_extra;
    logic [RIDX_W-1:0] cur_reg;
    logic              unused_insn;

    assign unused_insn = ^insn_i;

    stk_pick #(.W(LIST_W), .IW(IW)) u_pick (
        .mask_i     (seq_q.list),
        .hi_first_i (!seq_q.pop),
        .idx_o      (pick_idx),
        .any_o      (pick_any),
        .onehot_o   (pick_onehot)
    );

    stk_addr_unit #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_addr (
        .sp_i        (sp_i),
        .cur_i       (seq_q.addr),
        .start_pop_i (insn_i[POP_BIT]),
        .step_pop_i  (seq_q.pop),
        .start_o     (addr_start),
        .next_o      (addr_next),
        .final_sp_o  (sp_final)
    );

    // Extra register goes first on a push and last on a pop.
    assign cur_extra = seq_q.extra && (!seq_q.pop || !pick_any);
    assign cur_reg   = cur_extra ? (seq_q.pop ? REG_PC : REG_LR)
                                 : RIDX_W'(pick_idx);

    always_comb begin
        seq_d       = seq_q;
        rd_sel_o    = cur_reg;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = seq_q.addr;
        mem_wdata_o = rd_data_i;
        rf_we_o     = 1'b0;
        rf_waddr_o  = cur_reg;
        rf_wdata_o  = mem_rdata_i;
        done_o      = 1'b0;

        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.pop   = insn_i[POP_BIT];
                    seq_d.extra = insn_i[EXTRA_BIT];
                    seq_d.list  = insn_i[LIST_W-1:0];
                    seq_d.addr  = addr_start;
                    seq_d.empty = !(|insn_i[LIST_W-1:0]) && !insn_i[EXTRA_BIT];
                    seq_d.state = seq_d.empty ? ST_WB : ST_XFER;
                end
            end
            ST_XFER: begin
                mem_req_o = 1'b1;
                mem_we_o  = !seq_q.pop;
                if (mem_ready_i) begin
                    if (seq_q.pop) begin
                        rf_we_o    = 1'b1;
                        rf_wdata_o = cur_extra ? {mem_rdata_i[XLEN-1:1], 1'b0}
                                               : mem_rdata_i;
                    end
                    if (cur_extra) begin
                        seq_d.extra = 1'b0;
                    end else begin
                        seq_d.list = seq_q.list & ~pick_onehot;
                    end
                    seq_d.addr = addr_next;
                    if (!(|seq_d.list) && !seq_d.extra) begin
                        seq_d.state = ST_WB;
                    end
                end
            end
            ST_WB: begin
                done_o      = 1'b1;
                rf_we_o     = !seq_q.empty;
                rf_waddr_o  = REG_SP;
                rf_wdata_o  = sp_final;
                seq_d.state = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    // R8: a stalled access holds its request, address and direction.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=>
            mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R8: nothing is written to a register while a load is stalled.
    p_stall_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |-> !rf_we_o);

    // R3: back-to-back stores walk downward one word at a time.
    p_push_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o && $past(mem_req_o && mem_ready_i && mem_we_o)
            |-> mem_addr_o == $past(mem_addr_o) - STEP);

    // R5: back-to-back loads walk upward one word at a time.
    p_pop_asc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_we_o && $past(mem_req_o && mem_ready_i && !mem_we_o)
            |-> mem_addr_o == $past(mem_addr_o) + STEP);

    // R6: the program counter is never written with bit 0 set.
    p_pc_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o && rf_waddr_o == REG_PC |-> !rf_wdata_o[0]);

    // R4/R7: the stack pointer write appears only with the done pulse.
    p_sp_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o && rf_waddr_o == REG_SP |-> done_o && !mem_req_o);

    // R9: done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: a completion without a register write had no access before it.
    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !rf_we_o |-> !$past(mem_req_o));

endmodule

// File: tb/sim_stk_pushpop_seq.sv
module sim_stk_pushpop_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] sp;
    logic [3:0]  rd_sel;
    logic [31:0] rd_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        done;

    logic [31:0] rf_m  [16];
    logic [31:0] mem_m [256];

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
        logic [3:0]  rix;
    } acc_t;

    acc_t        q[$];
    logic [31:0] sp_exp;
    bit          exp_empty;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished_all = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    assign sp        = rf_m[13];
    assign rd_data   = rf_m[rd_sel];
    assign mem_rdata = mem_m[mem_addr[9:2]];

    stk_pushpop_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .insn_i(insn),
        .sp_i(sp), .rd_sel_o(rd_sel), .rd_data_i(rd_data),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_ready_i(mem_ready), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
        .rf_wdata_o(rf_wdata), .done_o(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(mem_req == 1'b0, tag, "mem_req idle", 32'(mem_req), 32'd0);
        chk(rf_we   == 1'b0, tag, "rf_we idle",   32'(rf_we),   32'd0);
        chk(done    == 1'b0, tag, "done idle",    32'(done),    32'd0);
    endtask

    // Behavioural model of the expected access list, from R2/R3/R5/R6.
    task automatic build(input logic [15:0] ins);
        logic [31:0] a;
        acc_t        e;
        q.delete();
        exp_empty = (ins[7:0] == 8'h00) && !ins[8];
        if (!ins[11]) begin
            a = rf_m[13] - 32'd4;
            if (ins[8]) begin
                e.addr = a; e.we = 1'b1; e.data = rf_m[14]; e.rix = 4'd14;
                q.push_back(e); a = a - 32'd4;
            end
            for (int i = 7; i >= 0; i--) begin
                if (ins[i]) begin
                    e.addr = a; e.we = 1'b1; e.data = rf_m[i]; e.rix = 4'(i);
                    q.push_back(e); a = a - 32'd4;
                end
            end
            sp_exp = a + 32'd4;
        end else begin
            a = rf_m[13];
            for (int i = 0; i < 8; i++) begin
                if (ins[i]) begin
                    e.addr = a; e.we = 1'b0; e.data = mem_m[a[9:2]]; e.rix = 4'(i);
                    q.push_back(e); a = a + 32'd4;
                end
            end
            if (ins[8]) begin
                e.addr = a; e.we = 1'b0; e.data = mem_m[a[9:2]] & 32'hFFFF_FFFE;
                e.rix = 4'd15;
                q.push_back(e); a = a + 32'd4;
            end
            sp_exp = a;
        end
    endtask

    task automatic run_op(input logic [15:0] ins, input bit stall, input bit inject);
        bit          fin;
        int          cyc;
        bit          is_push;
        string       tg;
        acc_t        h;
        is_push = !ins[11];
        @(negedge clk);
        build(ins);
        insn = ins; start = 1'b1; mem_ready = 1'b0;
        #1;
        chk_idle("R9");
        fin = 0; cyc = 0;
        while (!fin && cyc < 200) begin
            @(negedge clk);
            start = inject && (cyc == 0);
            if (inject && cyc == 0) insn = 16'h08FF;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
            #1;
            if (q.size() > 0) begin
                h  = q[0];
                tg = inject ? "R11" : (is_push ? "R3" : ((h.rix == 4'd15) ? "R6" : "R5"));
                chk(mem_req == 1'b1, tg, "mem_req", 32'(mem_req), 32'd1);
                chk(mem_addr == h.addr, tg, "mem_addr", mem_addr, h.addr);
                chk(mem_we == h.we, "R2", "mem_we", 32'(mem_we), 32'(h.we));
                chk(done == 1'b0, "R9", "done early", 32'(done), 32'd0);
                if (h.we)
                    chk(mem_wdata == h.data, tg, "store data", mem_wdata, h.data);
                if (!mem_ready) begin
                    chk(rf_we == 1'b0, "R8", "rf_we in stall", 32'(rf_we), 32'd0);
                end else begin
                    if (h.we) begin
                        chk(rf_we == 1'b0, "R3", "rf_we on store", 32'(rf_we), 32'd0);
                        mem_m[h.addr[9:2]] = h.data;
                    end else begin
                        chk(rf_we == 1'b1, tg, "rf_we on load", 32'(rf_we), 32'd1);
                        chk(rf_waddr == h.rix, tg, "rf_waddr", 32'(rf_waddr), 32'(h.rix));
                        chk(rf_wdata == h.data, tg, "rf_wdata", rf_wdata, h.data);
                        rf_m[h.rix] = h.data;
                    end
                    void'(q.pop_front());
                end
            end else begin
                tg = exp_empty ? "R10" : (is_push ? "R4" : "R7");
                chk(mem_req == 1'b0, tg, "mem_req at done", 32'(mem_req), 32'd0);
                chk(done == 1'b1, "R9", "done", 32'(done), 32'd1);
                chk(rf_we == !exp_empty, tg, "sp write", 32'(rf_we), 32'(!exp_empty));
                if (!exp_empty) begin
                    chk(rf_waddr == 4'd13, tg, "sp index", 32'(rf_waddr), 32'd13);
                    chk(rf_wdata == sp_exp, tg, "sp value", rf_wdata, sp_exp);
                    rf_m[13] = sp_exp;
                end
                fin = 1;
            end
            cyc++;
        end
        @(negedge clk);
        start = 1'b0; mem_ready = 1'b0;
        #1;
        chk_idle("R9");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf_m[i] = 32'h1000_0000 + 32'(i) * 32'h111;
        for (int i = 0; i < 256; i++) mem_m[i] = 32'hA500_0000 | 32'(i);
        rf_m[13] = 32'h0000_0300;
        rf_m[14] = 32'h0000_1235;
        repeat (3) @(negedge clk);
        #1;
        chk_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_idle("R1");

        // R3 R4: push LR, r7, r2, r0 with ready always high; odd bits ignored (R2)
        run_op(16'hB585, 1'b0, 1'b0);
        // R5 R6 R7: pop r0, r2, r7 and PC; odd LR value comes back even
        run_op(16'hBD85, 1'b0, 1'b0);
        // R8: full push under a stall pattern
        run_op(16'hB4FF, 1'b1, 1'b0);
        // R8 R6: full pop with PC under stalls
        run_op(16'hBDFF, 1'b1, 1'b0);
        // R10: empty push and empty pop
        run_op(16'hB400, 1'b0, 1'b0);
        run_op(16'hBC00, 1'b1, 1'b0);
        // R3: LR only; R6: PC only
        run_op(16'hB500, 1'b1, 1'b0);
        run_op(16'hBD00, 1'b1, 1'b0);
        // R11: start pulse during a running transfer is ignored
        run_op(16'hB448, 1'b1, 1'b1);
        // R2: unrelated high bits set, single register
        run_op(16'hF610, 1'b0, 1'b0);
        run_op(16'hFE10, 1'b1, 1'b0);

        finished_all = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished_all) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule